// File: doc/BRIEF.md
# 64-to-32-bit Pipelined Bus Width Bridge

This block connects a 64-bit pipelined Wishbone master to a 32-bit Wishbone IO port. Each request from the wide side is first captured in a register stage, which keeps the wide interconnect's timing paths short. The block then issues zero, one or two 32-bit beats on the narrow side, depending on which 32-bit halves the eight byte selects enable.

For reads, each returned 32-bit word is placed into its own half of a 64-bit return register. Halves that were not selected read as zero. The wide side sees a single acknowledge when the last narrow beat completes. A request with no byte selects set is acknowledged without any narrow-side activity.

The wide side uses byte addresses. The narrow side uses 32-bit word addresses: the 8-byte-aligned part of the wide address, followed by one bit that names the half. Both sides use stall for flow control.

Top module: `wide2io_bridge`

## Requirements
- R1: After synchronous active-high reset, every output is zero: up_ack, up_stall, up_rdat, io_cyc, io_stb, io_we, io_adr, io_wdat and io_sel.
- R2: A wide request is taken only in a cycle with up_cyc, up_stb high and up_stall low. It is held in a register, and in the cycle after acceptance io_cyc and io_stb are still low.
- R3: From the cycle after acceptance until the acknowledge cycle, up_stall stays high, so no second request is taken.
- R4: When up_sel[3:0] is nonzero, a low beat is issued with io_adr = {up_adr[31:3], 0}, io_sel = up_sel[3:0] and io_wdat = up_wdat[31:0].
- R5: When up_sel[7:4] is nonzero, a high beat is issued with io_adr = {up_adr[31:3], 1}, io_sel = up_sel[7:4] and io_wdat = up_wdat[63:32].
- R6: When both halves are selected, the low beat is issued before the high beat, and io_cyc stays high from the first beat to the last io_ack.
- R7: On a read acknowledge, up_rdat[31:0] holds the low-beat data and up_rdat[63:32] holds the high-beat data. A half that was not selected is zero.
- R8: Exactly one up_ack pulse is given per request. It comes one cycle after the last io_ack, and io_cyc is low in that cycle.
- R9: With up_sel all zero, no IO beat is issued and io_cyc stays low. up_ack comes two cycles after the acceptance edge.
- R10: While io_stb is high and io_stall is high, the beat is held: io_stb stays high, and io_adr and io_sel do not change.
- R11: In the up_ack cycle up_stall is low, so a new request presented in that cycle is accepted at the same edge that ends the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_cyc | input | 1 | Wide-side bus cycle |
| up_stb | input | 1 | Wide-side request strobe |
| up_we | input | 1 | Wide-side write enable |
| up_adr | input | 32 | Wide-side byte address |
| up_wdat | input | 64 | Wide-side write data |
| up_sel | input | 8 | Wide-side byte selects |
| up_rdat | output | 64 | Read data returned to the wide side |
| up_ack | output | 1 | Wide-side acknowledge pulse |
| up_stall | output | 1 | Wide-side stall |
| io_cyc | output | 1 | Narrow-side bus cycle |
| io_stb | output | 1 | Narrow-side request strobe |
| io_we | output | 1 | Narrow-side write enable |
| io_adr | output | 30 | Narrow-side word address |
| io_wdat | output | 32 | Narrow-side write data |
| io_sel | output | 4 | Narrow-side byte selects |
| io_rdat | input | 32 | Narrow-side read data |
| io_ack | input | 1 | Narrow-side acknowledge |
| io_stall | input | 1 | Narrow-side stall |

## Verification
Two functions can fall in the same cycle: the acknowledge that ends one request and the acceptance of the next. When a following request is already waiting with its strobe high, the ack cycle is also the cycle in which up_stall drops.

The bench provokes this by presenting a second request while the first is still in flight. It then checks three things: up_stall is low in the ack cycle, the first request's read data is still correct while the return register is being cleared for the second, and the second request later returns its own data. Every byte-select pattern is also swept for both reads and writes, against a narrow-side model that stalls at random.

// File: rtl/w2n_pkg.sv
package w2n_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_REQ   = 2'd2,
    ST_WAIT  = 2'd3
  } w2n_state_t;

endpackage

// File: rtl/w2n_capture.sv
module w2n_capture #(
  parameter int PAIR_AW = 29,
  parameter int WIDE_DW = 64,
  parameter int WSEL    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [PAIR_AW-1:0] in_pair,
  input  logic [WIDE_DW-1:0] in_dat,
  input  logic [WSEL-1:0]    in_sel,
  input  logic               in_we,
  output logic [PAIR_AW-1:0] q_pair,
  output logic [WIDE_DW-1:0] q_dat,
  output logic [WSEL-1:0]    q_sel,
  output logic               q_we
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_pair <= '0;
      q_dat  <= '0;
      q_sel  <= '0;
      q_we   <= 1'b0;
    end else if (load) begin
      q_pair <= in_pair;
      q_dat  <= in_dat;
      q_sel  <= in_sel;
      q_we   <= in_we;
    end
  end

endmodule

// File: rtl/w2n_beat_ctrl.sv
module w2n_beat_ctrl
  import w2n_pkg::*;
#(
  parameter int PAIR_AW   = 29,
  parameter int WIDE_DW   = 64,
  parameter int NARROW_DW = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   up_cyc,
  input  logic                   up_stb,
  input  logic [PAIR_AW-1:0]     q_pair,
  input  logic [WIDE_DW-1:0]     q_dat,
  input  logic [WIDE_DW/8-1:0]   q_sel,
  input  logic                   q_we,
  input  logic                   io_stall,
  input  logic                   io_ack,
  output logic                   accept,
  output logic                   beat_done,
  output logic                   beat_hi,
  output logic                   up_stall,
  output logic                   up_ack,
  output logic                   io_cyc,
  output logic                   io_stb,
  output logic                   io_we,
  output logic [PAIR_AW:0]       io_adr,
  output logic [NARROW_DW-1:0]   io_wdat,
  output logic [NARROW_DW/8-1:0] io_sel
);

  localparam int NSEL = NARROW_DW / 8;
  localparam int WSEL = WIDE_DW / 8;

  w2n_state_t state;
  logic lo_en, hi_en, nxt_hi;
  logic [NARROW_DW-1:0] nxt_dat;
  logic [NSEL-1:0]      nxt_sel;

  assign accept    = up_cyc & up_stb & ~up_stall;
  assign beat_done = (state == ST_WAIT) & io_ack;
  assign lo_en     = |q_sel[NSEL-1:0];
  assign hi_en     = |q_sel[WSEL-1:NSEL];

  // Half for the beat about to launch: from START the low half wins if enabled;
  // the only later launch is the high half.
  always_comb begin
    nxt_hi  = (state == ST_START) ? ~lo_en : 1'b1;
    nxt_dat = nxt_hi ? q_dat[WIDE_DW-1:NARROW_DW] : q_dat[NARROW_DW-1:0];
    nxt_sel = nxt_hi ? q_sel[WSEL-1:NSEL] : q_sel[NSEL-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      up_stall <= 1'b0;
      up_ack   <= 1'b0;
      io_cyc   <= 1'b0;
      io_stb   <= 1'b0;
      io_we    <= 1'b0;
      io_adr   <= '0;
      io_wdat  <= '0;
      io_sel   <= '0;
      beat_hi  <= 1'b0;
    end else begin
      up_ack <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            up_stall <= 1'b1;
            state    <= ST_START;
          end
        end
        ST_START: begin
          if (!lo_en && !hi_en) begin
            up_ack   <= 1'b1;
            up_stall <= 1'b0;
            state    <= ST_IDLE;
          end else begin
            io_cyc  <= 1'b1;
            io_stb  <= 1'b1;
            io_we   <= q_we;
            io_adr  <= {q_pair, nxt_hi};
            io_wdat <= nxt_dat;
            io_sel  <= nxt_sel;
            beat_hi <= nxt_hi;
            state   <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (!io_stall) begin
            io_stb <= 1'b0;
            state  <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (io_ack) begin
            if (!beat_hi && hi_en) begin
              io_stb  <= 1'b1;
              io_adr  <= {q_pair, nxt_hi};
              io_wdat <= nxt_dat;
              io_sel  <= nxt_sel;
              beat_hi <= nxt_hi;
              state   <= ST_REQ;
            end else begin
              io_cyc   <= 1'b0;
              up_ack   <= 1'b1;
              up_stall <= 1'b0;
              state    <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_no_early_beat_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!io_stb && !io_cyc));

  assert_busy_stalls_R3: assert property (@(posedge clk) disable iff (rst)
    io_cyc |-> up_stall);

  assert_strobe_in_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    io_stb |-> io_cyc);

  assert_single_ack_R8: assert property (@(posedge clk) disable iff (rst)
    up_ack |=> !up_ack);

  assert_ack_ends_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    up_ack |-> !io_cyc);

  assert_beat_held_R10: assert property (@(posedge clk) disable iff (rst)
    (io_stb && io_stall) |=> (io_stb && $stable(io_adr) && $stable(io_sel)));

  assert_ack_reopens_R11: assert property (@(posedge clk) disable iff (rst)
    up_ack |-> !up_stall);

endmodule

// File: rtl/w2n_collect.sv
module w2n_collect #(
  parameter int WIDE_DW   = 64,
  parameter int NARROW_DW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear,
  input  logic                 beat_done,
  input  logic                 beat_hi,
  input  logic                 is_write,
  input  logic [NARROW_DW-1:0] io_rdat,
  output logic [WIDE_DW-1:0]   up_rdat
);

  localparam int LANES = WIDE_DW / NARROW_DW;

  for (genvar h = 0; h < LANES; h++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        up_rdat[h*NARROW_DW +: NARROW_DW] <= '0;
      end else if (beat_done && !is_write && (beat_hi == 1'(h))) begin
        up_rdat[h*NARROW_DW +: NARROW_DW] <= io_rdat;
      end
    end
  end

  assert_cleared_on_accept_R7: assert property (@(posedge clk) disable iff (rst)
    clear |=> (up_rdat == '0));

endmodule

// File: rtl/wide2io_bridge.sv
module wide2io_bridge #(
  parameter int ADDR_W    = 32,
  parameter int WIDE_DW   = 64,
  parameter int NARROW_DW = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   up_cyc,
  input  logic                   up_stb,
  input  logic                   up_we,
  input  logic [ADDR_W-1:0]      up_adr,
  input  logic [WIDE_DW-1:0]     up_wdat,
  input  logic [WIDE_DW/8-1:0]   up_sel,
  output logic [WIDE_DW-1:0]     up_rdat,
  output logic                   up_ack,
  output logic                   up_stall,
  output logic                   io_cyc,
  output logic                   io_stb,
  output logic                   io_we,
  output logic [ADDR_W-$clog2(NARROW_DW/8)-1:0] io_adr,
  output logic [NARROW_DW-1:0]   io_wdat,
  output logic [NARROW_DW/8-1:0] io_sel,
  input  logic [NARROW_DW-1:0]   io_rdat,
  input  logic                   io_ack,
  input  logic                   io_stall
);

  localparam int WSEL    = WIDE_DW / 8;
  localparam int OFF     = $clog2(WSEL);
  localparam int PAIR_AW = ADDR_W - OFF;

  logic               accept, beat_done, beat_hi;
  logic [PAIR_AW-1:0] q_pair;
  logic [WIDE_DW-1:0] q_dat;
  logic [WSEL-1:0]    q_sel;
  logic               q_we;
  logic               unused_lsb;

  assign unused_lsb = ^up_adr[OFF-1:0];

  w2n_capture #(.PAIR_AW(PAIR_AW), .WIDE_DW(WIDE_DW), .WSEL(WSEL)) capture_i (
    .clk(clk), .rst(rst), .load(accept),
    .in_pair(up_adr[ADDR_W-1:OFF]), .in_dat(up_wdat), .in_sel(up_sel), .in_we(up_we),
    .q_pair(q_pair), .q_dat(q_dat), .q_sel(q_sel), .q_we(q_we)
  );

  w2n_beat_ctrl #(.PAIR_AW(PAIR_AW), .WIDE_DW(WIDE_DW), .NARROW_DW(NARROW_DW)) ctrl_i (
    .clk(clk), .rst(rst), .up_cyc(up_cyc), .up_stb(up_stb),
    .q_pair(q_pair), .q_dat(q_dat), .q_sel(q_sel), .q_we(q_we),
    .io_stall(io_stall), .io_ack(io_ack),
    .accept(accept), .beat_done(beat_done), .beat_hi(beat_hi),
    .up_stall(up_stall), .up_ack(up_ack),
    .io_cyc(io_cyc), .io_stb(io_stb), .io_we(io_we),
    .io_adr(io_adr), .io_wdat(io_wdat), .io_sel(io_sel)
  );

  w2n_collect #(.WIDE_DW(WIDE_DW), .NARROW_DW(NARROW_DW)) collect_i (
    .clk(clk), .rst(rst), .clear(accept), .beat_done(beat_done),
    .beat_hi(beat_hi), .is_write(q_we), .io_rdat(io_rdat), .up_rdat(up_rdat)
  );

endmodule

// File: tb/wide2io_bridge_tb_top.sv
`timescale 1ns/1ps
module wide2io_bridge_tb_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic        up_cyc = 1'b0, up_stb = 1'b0, up_we = 1'b0;
  logic [31:0] up_adr = '0;
  logic [63:0] up_wdat = '0;
  logic [7:0]  up_sel = '0;
  logic [63:0] up_rdat;
  logic        up_ack, up_stall;
  logic        io_cyc, io_stb, io_we;
  logic [29:0] io_adr;
  logic [31:0] io_wdat;
  logic [3:0]  io_sel;
  logic [31:0] io_rdat = '0;
  logic        io_ack = 1'b0;
  logic        io_stall = 1'b0;

  wide2io_bridge dut_i (
    .clk(clk), .rst(rst), .up_cyc(up_cyc), .up_stb(up_stb), .up_we(up_we),
    .up_adr(up_adr), .up_wdat(up_wdat), .up_sel(up_sel), .up_rdat(up_rdat),
    .up_ack(up_ack), .up_stall(up_stall), .io_cyc(io_cyc), .io_stb(io_stb),
    .io_we(io_we), .io_adr(io_adr), .io_wdat(io_wdat), .io_sel(io_sel),
    .io_rdat(io_rdat), .io_ack(io_ack), .io_stall(io_stall)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rfun(input logic [29:0] a);
    return {a[13:0], a[29:12]} ^ 32'hC3A5_5A3C;
  endfunction

  // Narrow-side model: pipelined slave with one-cycle ack latency and random stall
  int          edge_n = 0;
  int          nbeats = 0, n_upack = 0, n_cycseen = 0;
  int          last_ioack_n = 0, upack_n = 0;
  logic        clr_log = 1'b0;
  logic        stall_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [29:0] lg_adr [2];
  logic [31:0] lg_dat [2];
  logic [3:0]  lg_sel [2];
  logic        lg_we  [2];

  always @(negedge clk) begin
    lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    io_stall <= stall_mode & lfsr[0];
  end

  always @(posedge clk) begin
    edge_n <= edge_n + 1;
    io_ack <= 1'b0;
    if (io_stb && !io_stall && !rst) begin
      io_ack  <= 1'b1;
      io_rdat <= rfun(io_adr);
    end
    if (io_ack) last_ioack_n <= edge_n;
    if (up_ack) upack_n <= edge_n;
    if (clr_log) begin
      nbeats <= 0; n_upack <= 0; n_cycseen <= 0;
    end else begin
      if (io_cyc) n_cycseen <= n_cycseen + 1;
      if (up_ack) n_upack <= n_upack + 1;
      if (io_stb && !io_stall) begin
        if (nbeats < 2) begin
          lg_adr[nbeats] <= io_adr; lg_dat[nbeats] <= io_wdat;
          lg_sel[nbeats] <= io_sel; lg_we[nbeats]  <= io_we;
        end
        nbeats <= nbeats + 1;
      end
    end
  end

  task automatic wait_ack();
    int t = 0;
    while (!up_ack && t < 300) begin @(negedge clk); t++; end
    check(up_ack, "R8 ack arrives", {63'd0, up_ack}, 64'd1);
  endtask

  task automatic run_one(input logic [31:0] a, input logic [63:0] d, input logic [7:0] s, input logic w);
    int acc_n, k;
    logic lo, hi;
    logic [63:0] exp_r;
    lo = |s[3:0]; hi = |s[7:4];
    @(negedge clk);
    clr_log = 1'b1;
    up_cyc = 1'b1; up_stb = 1'b1; up_adr = a; up_wdat = d; up_sel = s; up_we = w;
    while (up_stall) @(negedge clk);
    acc_n = edge_n;
    @(negedge clk);
    clr_log = 1'b0; up_stb = 1'b0;
    check(up_stall && !io_stb && !io_cyc, "R2 R3 latched, stalled, no beat yet",
          {61'd0, up_stall, io_stb, io_cyc}, 64'h4);
    wait_ack();
    exp_r = {hi ? rfun({a[31:3], 1'b1}) : 32'h0, lo ? rfun({a[31:3], 1'b0}) : 32'h0};
    if (!w) check(up_rdat == exp_r, "R7 read gather", up_rdat, exp_r);
    check(!up_stall, "R11 stall low in ack cycle", {63'd0, up_stall}, 64'd0);
    @(negedge clk); @(negedge clk);
    up_cyc = 1'b0;
    check(n_upack == 1, "R8 single ack", 64'(n_upack), 64'd1);
    check(nbeats == int'(lo) + int'(hi), "R4 R5 beat count", 64'(nbeats), 64'(int'(lo) + int'(hi)));
    if (!lo && !hi) begin
      check(n_cycseen == 0, "R9 no IO cycle", 64'(n_cycseen), 64'd0);
      check(upack_n == acc_n + 2, "R9 ack latency", 64'(upack_n), 64'(acc_n + 2));
    end else begin
      check(upack_n == last_ioack_n + 1, "R8 ack after last io_ack", 64'(upack_n), 64'(last_ioack_n + 1));
      check(n_cycseen == upack_n - acc_n - 2, "R6 cyc held through beats",
            64'(n_cycseen), 64'(upack_n - acc_n - 2));
    end
    k = 0;
    if (lo) begin
      check(lg_adr[0] == {a[31:3], 1'b0} && lg_sel[0] == s[3:0] && lg_we[0] == w,
            "R4 low beat addr/sel", {30'd0, lg_adr[0], lg_sel[0]}, {30'd0, a[31:3], 1'b0, s[3:0]});
      if (w) check(lg_dat[0] == d[31:0], "R4 low write data", 64'(lg_dat[0]), 64'(d[31:0]));
      k = 1;
    end
    if (hi) begin
      check(lg_adr[k] == {a[31:3], 1'b1} && lg_sel[k] == s[7:4] && lg_we[k] == w,
            "R5 R6 high beat addr/sel/order", {30'd0, lg_adr[k], lg_sel[k]}, {30'd0, a[31:3], 1'b1, s[7:4]});
      if (w) check(lg_dat[k] == d[63:32], "R5 high write data", 64'(lg_dat[k]), 64'(d[63:32]));
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(4ns * 150000);
    check(1'b0, "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    logic [31:0] a, b;
    repeat (3) @(negedge clk);
    // R1: reset values at the ports
    check({up_ack, up_stall, io_cyc, io_stb, io_we} == 5'd0 && up_rdat == '0 &&
          io_adr == '0 && io_wdat == '0 && io_sel == '0, "R1 reset state",
          {59'd0, up_ack, up_stall, io_cyc, io_stb, io_we}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    // Sweep every select pattern for read and write, stall on for half the runs
    for (int w = 0; w < 2; w++) begin
      for (int s = 0; s < 256; s++) begin
        stall_mode = s[1] ^ w[0];
        a = 32'h1000_0000 ^ (32'(s) * 32'h0001_0108) ^ (32'(w) << 20);
        run_one(a, {a ^ 32'h5555_AAAA, ~a}, 8'(s), w[0]);
      end
    end
    // R11: next request waits with strobe high and is taken in the ack cycle
    stall_mode = 1'b1;
    a = 32'h2468_ACE0; b = 32'h1357_9BD8;
    @(negedge clk);
    clr_log = 1'b1;
    up_cyc = 1'b1; up_stb = 1'b1; up_we = 1'b0; up_sel = 8'hFF; up_adr = a;
    while (up_stall) @(negedge clk);
    @(negedge clk);
    clr_log = 1'b0;
    up_adr = b; up_sel = 8'hF0;
    wait_ack();
    check(up_rdat == {rfun({a[31:3], 1'b1}), rfun({a[31:3], 1'b0})}, "R11 first data at overlap",
          up_rdat, {rfun({a[31:3], 1'b1}), rfun({a[31:3], 1'b0})});
    check(!up_stall && up_stb, "R11 next request visible unstalled", {62'd0, up_stall, up_stb}, 64'd1);
    @(negedge clk);
    up_stb = 1'b0;
    check(up_stall && up_rdat == '0, "R11 R7 second accepted, data cleared", {63'd0, up_stall}, 64'd1);
    wait_ack();
    check(up_rdat == {rfun({b[31:3], 1'b1}), 32'h0}, "R11 second data", up_rdat,
          {rfun({b[31:3], 1'b1}), 32'h0});
    @(negedge clk);
    up_cyc = 1'b0;
    // R1: reset again mid-idle returns outputs to zero
    rst = 1'b1;
    @(negedge clk);
    check(up_rdat == '0 && !up_ack && !io_cyc && io_adr == '0, "R1 reset clears return data",
          up_rdat, 64'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule